// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a small counter that walks through a fixed loop of five 3-bit codes, one step per enabled clock edge. The codes are not binary counts, and the register bits are the output. The loop, with the bits written as `{c,b,a}` = `q[2:0]`, is 000, 010, 011, 101, 110, and then back to 000.

The three codes outside the loop each have a fixed successor. A register that wakes up in an unused code therefore reaches the loop within at most two enabled steps. A `valid` output is high while the current code belongs to the loop.

A load port lets the counter be placed in any code. Test logic uses it to place the counter in an unused code and watch it recover.

Top module: `seq5_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `q` becomes 000 on that edge. Reset takes priority over load and enable.
- R2: With `en` high and `ld` and `rst` low, each edge advances a loop code to its successor: 000→010, 010→011, 011→101, 101→110, 110→000.
- R3: With `en` high and `ld` and `rst` low, the unused code 001 steps to 110.
- R4: With `en` high and `ld` and `rst` low, the unused code 100 steps to 010.
- R5: With `en` high and `ld` and `rst` low, the unused code 111 steps to 100, and the next enabled step reaches 010.
- R6: With `en`, `ld` and `rst` low, `q` keeps its value across the edge.
- R7: With `ld` high and `rst` low, `q` takes `ld_val` on the edge, whatever the value of `en`.
- R8: `valid` is 1 exactly when `q` is one of 000, 010, 011, 101 or 110, and is 0 for 001, 100 and 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to code 000 |
| en | input | 1 | Step enable |
| ld | input | 1 | Load `ld_val` into the state |
| ld_val | input | 3 | Code to load |
| q | output | 3 | Current code `{c,b,a}` |
| valid | output | 1 | Current code is in the five-code loop |

## Verification
The bench loads each of the three unused codes and steps the counter. A design with a wrong successor for one of them would stay in unused codes or enter the loop at the wrong point. This also catches a cycle that never returns to the loop. Hold cycles with `en` low catch a counter that keeps stepping. Loads made with `en` low catch a load gated by enable. Reset asserted together with load catches a wrong priority order. Randomly mixed reset, load and enable patterns, checked against a table model, expose a misordered loop step and a `valid` flag that decodes the wrong codes.

// File: rtl/seq5_counter.sv
module seq5_counter (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       ld,
  input  logic [2:0] ld_val,
  output logic [2:0] q,
  output logic       valid
);

  logic c, b, a;
  logic [2:0] step;

  assign {c, b, a} = q;

  assign step = {a, ~b | (~a & ~c), b & ~c};

  always_ff @(posedge clk) begin
    if (rst)     q <= 3'b000;
    else if (ld) q <= ld_val;
    else if (en) q <= step;
  end

  assign valid = (q == 3'b000) | (q == 3'b010) | (q == 3'b011) |
                 (q == 3'b101) | (q == 3'b110);

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> q == 3'b000);

  p_loop_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !ld && valid) |=> (valid && q != $past(q)));

  p_from001_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !ld && q == 3'b001) |=> q == 3'b110);

  p_from100_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !ld && q == 3'b100) |=> q == 3'b010);

  p_from111_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !ld && q == 3'b111) |=> q == 3'b100);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!en && !ld) |=> $stable(q));

  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(ld_val));

endmodule

// File: tb/seq5_counter_tb.sv
`timescale 1ns/1ps
module seq5_counter_tb;
  logic clk = 1'b0;
  logic rst, en, ld;
  logic [2:0] ld_val;
  logic [2:0] q;
  logic valid;
  logic [2:0] exp_q;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  seq5_counter u_dut (.clk(clk), .rst(rst), .en(en), .ld(ld), .ld_val(ld_val),
                      .q(q), .valid(valid));

  function automatic logic [2:0] f_next(input logic [2:0] s);
    case (s)
      3'b000: return 3'b010;
      3'b010: return 3'b011;
      3'b011: return 3'b101;
      3'b101: return 3'b110;
      3'b110: return 3'b000;
      3'b001: return 3'b110;
      3'b100: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic logic f_valid(input logic [2:0] s);
    return (s == 3'b000) || (s == 3'b010) || (s == 3'b011) ||
           (s == 3'b101) || (s == 3'b110);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic cyc(input logic r, input logic e, input logic l,
                     input logic [2:0] v, input string tag);
    @(negedge clk);
    rst = r; en = e; ld = l; ld_val = v;
    if (r) exp_q = 3'b000;
    else if (l) exp_q = v;
    else if (e) exp_q = f_next(exp_q);
    @(posedge clk);
    #1;
    chk(q === exp_q, tag, int'(q), int'(exp_q));
    chk(valid === f_valid(exp_q), "R8", int'(valid), int'(f_valid(exp_q)));
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; ld = 1'b0; ld_val = 3'b000; exp_q = 3'b000;
    void'($urandom(32'd4711));
    cyc(1, 0, 0, 3'b000, "R1");
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 3'b000, "R2");
    cyc(0, 1, 1, 3'b001, "R7");
    cyc(0, 1, 0, 3'b000, "R3");
    cyc(0, 1, 1, 3'b100, "R7");
    cyc(0, 1, 0, 3'b000, "R4");
    cyc(0, 1, 1, 3'b111, "R7");
    cyc(0, 1, 0, 3'b000, "R5");
    cyc(0, 1, 0, 3'b000, "R5");
    cyc(0, 0, 0, 3'b000, "R6");
    cyc(0, 0, 0, 3'b000, "R6");
    for (int k = 0; k < 8; k++) begin
      cyc(0, 0, 1, 3'(k), "R7");
      cyc(0, 0, 0, 3'b000, "R6");
    end
    cyc(1, 1, 1, 3'b111, "R1");
    for (int n = 0; n < 3000; n++) begin
      logic r, e, l;
      logic [2:0] v;
      r = ($urandom % 40) == 0;
      l = ($urandom % 8) == 0;
      e = ($urandom % 4) != 0;
      v = 3'($urandom);
      cyc(r, e, l, v, r ? "R1" : l ? "R7" : e ? "R2" : "R6");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule